// File: doc/BRIEF.md
# Pulse-Interval Bit Demodulator

This block turns a stream of peak time stamps from a sampled low-frequency tag reply into framed data blocks. Each accepted peak is compared with the previous reference time, and the elapsed interval is sorted against a nominal bit period of 64 samples. A full-period interval yields a one. Two half-period intervals yield a zero. A quarter-period interval that follows another quarter-period interval, or a half-period interval that follows one, marks the gap between blocks. Any other interval is an error.

At each block gap the bits gathered since the previous gap are checked. When exactly 128 were collected, they are presented as one 128-bit word: sixteen bytes, each filled least significant bit first. After a gap, a fixed stretch of samples is skipped. Decoding stops for good after four blocks or after too many errors, and only a reset restarts it. An upstream peak detector feeds the block, and a consumer latches each word on its valid pulse.

Top module: `pulse_iv_demod`

## Requirements
- R1: With interval d = pk_time minus the reference time, modulo 2^16, a peak falls in the quarter class for 9 <= d <= 23, the half class for 25 <= d <= 39 and the full class for 57 <= d <= 71. Any other d is unmatched and raises `ev_err` for one cycle, in the cycle after the peak is sampled.
- R2: After reset, the first peak produces no event and only becomes the reference time. Every later accepted peak becomes the new reference, except a gap peak (R4, R5).
- R3: A full-class peak appends a 1. A half-class peak that does not follow a quarter-class peak toggles a pending flag, and appends a 0 when the flag was already set. A full-class peak between two half-class peaks leaves the flag as it is.
- R4: A quarter-class peak that directly follows a quarter-class peak is a block gap. The reference becomes the gap time plus 351.
- R5: A half-class peak that directly follows a quarter-class peak is a block gap. The reference becomes the gap time plus 335.
- R6: After a gap, a peak whose time is not later than the new reference (signed 16-bit difference zero or negative) is ignored. It raises no event and leaves the reference unchanged.
- R7: At a gap, `blk_valid` pulses for one cycle, one cycle after the gap peak, only if exactly 128 bits were appended since the previous gap or reset. The bit count and the pending half flag are then cleared.
- R8: The k-th appended bit of a block (k from 0) appears at `blk_data[k]`, so byte j occupies bits 8j+7..8j with its first bit in bit 0. The word holds until the next valid pulse.
- R9: `dec_done` rises together with the fourth `blk_valid` pulse and stays set. After that, peaks produce no `blk_valid` and no `ev_err`.
- R10: Ten errors leave decoding running. The eleventh raises `ev_err` and sets `dec_abort` in the same cycle, and `dec_abort` stays set. After that, peaks produce no events.
- R11: During and right after reset, `blk_valid`, `ev_err`, `dec_abort` and `dec_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_valid | input | 1 | A peak time stamp is present this cycle |
| pk_time | input | 16 | Sample index of the peak |
| blk_valid | output | 1 | One-cycle pulse: a complete block is on blk_data |
| blk_data | output | 128 | Block word, bit k = k-th received bit |
| ev_err | output | 1 | One-cycle pulse: the last peak matched no class |
| dec_abort | output | 1 | Sticky: error limit exceeded |
| dec_done | output | 1 | Sticky: four blocks delivered |

## Verification
Two functions can land on the same clock edge. One is the final block delivery together with the done flag. The other is the limit-crossing error pulse together with the abort flag. The bench provokes the first by closing the fourth valid block with a short gap. It checks `blk_valid`, the data word and `dec_done` all at the sample right after that peak. It provokes the second by counting ten errors without an abort and then sending an eleventh, expecting `ev_err` and `dec_abort` together. It then confirms that later in-class and out-of-class peaks raise nothing.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_QTR  = 2'd1,
    CL_HALF = 2'd2,
    CL_FULL = 2'd3
  } pid_cls_e;

  // Samples skipped after a block gap; the reference lands on the last skipped sample.
  localparam int GAP_SPAN_QQ = 128 + 127 + 16 + 32 + 33 + 16 - 1;
  localparam int GAP_SPAN_QH = 128 + 127 + 16 + 32 + 33 - 1;

  // Strict window: |iv - ctr| < tol
  function automatic logic in_band(input int iv, input int ctr, input int tol);
    return ((iv - ctr) < tol) && ((ctr - iv) < tol);
  endfunction

  function automatic pid_cls_e classify(input int iv, input int nom);
    int tol;
    tol = nom / 8;
    if (in_band(iv, nom / 4, tol)) return CL_QTR;
    if (in_band(iv, nom / 2, tol)) return CL_HALF;
    if (in_band(iv, nom, tol))     return CL_FULL;
    return CL_NONE;
  endfunction

endpackage

// File: rtl/pid_interval.sv
module pid_interval
  import pid_pkg::*;
#(
  parameter int TW  = 16,
  parameter int NOM = 64
) (
  input  logic [TW-1:0] t_now,
  input  logic [TW-1:0] t_ref,
  input  logic          skipping,
  output logic [TW-1:0] iv,
  output pid_cls_e      cls,
  output logic          in_win
);

  always_comb begin
    iv     = t_now - t_ref;
    cls    = classify(int'(iv), NOM);
    in_win = skipping && ((iv == '0) || iv[TW-1]);
  end

endmodule

// File: rtl/pid_framer.sv
module pid_framer #(
  parameter int BLK_BITS = 128,
  parameter int CW       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_vld,
  input  logic                bit_val,
  input  logic                clr,
  output logic [BLK_BITS-1:0] sr,
  output logic [CW-1:0]       cnt
);

  localparam logic [CW-1:0] CNT_SAT = CW'(BLK_BITS + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      if (bit_vld) sr <= {bit_val, sr[BLK_BITS-1:1]};
      if (clr) cnt <= '0;
      else if (bit_vld && cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_SAT);
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/pid_tally.sv
module pid_tally #(
  parameter int MAX_ERR = 10,
  parameter int MAX_BLK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_ev,
  input  logic blk_ev,
  output logic abort,
  output logic done
);

  localparam int EW = $clog2(MAX_ERR + 2);
  localparam int BW = $clog2(MAX_BLK + 1);

  logic [EW-1:0] ecnt;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt  <= '0;
      bcnt  <= '0;
      abort <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (err_ev) begin
        ecnt <= ecnt + 1'b1;
        if (ecnt == EW'(MAX_ERR)) abort <= 1'b1;
      end
      if (blk_ev) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt == BW'(MAX_BLK - 1)) done <= 1'b1;
      end
    end
  end

  p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> abort);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_no_count_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort || done) |-> !(err_ev || blk_ev));

endmodule

// File: rtl/pulse_iv_demod.sv
module pulse_iv_demod
  import pid_pkg::*;
#(
  parameter int TW       = 16,
  parameter int NOM      = 64,
  parameter int BLK_BITS = 128,
  parameter int MAX_ERR  = 10,
  parameter int MAX_BLK  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pk_valid,
  input  logic [TW-1:0]       pk_time,
  output logic                blk_valid,
  output logic [BLK_BITS-1:0] blk_data,
  output logic                ev_err,
  output logic                dec_abort,
  output logic                dec_done
);

  localparam int CW = $clog2(BLK_BITS + 2);
  localparam logic [TW-1:0] SPAN_QQ = TW'(GAP_SPAN_QQ);
  localparam logic [TW-1:0] SPAN_QH = TW'(GAP_SPAN_QH);

  logic                armed, skipping, prev_q, half_pend;
  logic [TW-1:0]       ref_t, iv;
  pid_cls_e            cls;
  logic                in_win;
  logic [BLK_BITS-1:0] sr;
  logic [CW-1:0]       bit_cnt;

  // named internal events
  logic run, arm_ev, acc, gap_qq, gap_qh, gap_ev, emit_bit, bit_val, err_ev, blk_ev;

  pid_interval #(.TW(TW), .NOM(NOM)) iv_i (
    .t_now(pk_time), .t_ref(ref_t), .skipping(skipping),
    .iv(iv), .cls(cls), .in_win(in_win)
  );

  always_comb begin
    run      = !dec_abort && !dec_done;
    arm_ev   = pk_valid && run && !armed;
    acc      = pk_valid && run && armed && !in_win;
    gap_qq   = acc && prev_q && (cls == CL_QTR);
    gap_qh   = acc && prev_q && (cls == CL_HALF);
    gap_ev   = gap_qq || gap_qh;
    emit_bit = acc && ((cls == CL_FULL) || ((cls == CL_HALF) && !prev_q && half_pend));
    bit_val  = (cls == CL_FULL);
    err_ev   = acc && (cls == CL_NONE);
    blk_ev   = gap_ev && (bit_cnt == CW'(BLK_BITS));
  end

  pid_framer #(.BLK_BITS(BLK_BITS), .CW(CW)) fr_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(emit_bit), .bit_val(bit_val),
    .clr(gap_ev), .sr(sr), .cnt(bit_cnt)
  );

  pid_tally #(.MAX_ERR(MAX_ERR), .MAX_BLK(MAX_BLK)) ty_i (
    .clk(clk), .rst_n(rst_n), .err_ev(err_ev), .blk_ev(blk_ev),
    .abort(dec_abort), .done(dec_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      skipping  <= 1'b0;
      prev_q    <= 1'b0;
      half_pend <= 1'b0;
      ref_t     <= '0;
      blk_valid <= 1'b0;
      blk_data  <= '0;
      ev_err    <= 1'b0;
    end else begin
      blk_valid <= blk_ev;
      ev_err    <= err_ev;
      if (blk_ev) blk_data <= sr;
      if (arm_ev) begin
        armed <= 1'b1;
        ref_t <= pk_time;
      end
      if (acc) begin
        skipping <= gap_ev;
        prev_q   <= (cls == CL_QTR) && !prev_q;
        if (gap_qq)      ref_t <= pk_time + SPAN_QQ;
        else if (gap_qh) ref_t <= pk_time + SPAN_QH;
        else             ref_t <= pk_time;
        if (gap_ev) half_pend <= 1'b0;
        else if (cls == CL_HALF) half_pend <= !half_pend;
      end
    end
  end

  p_block_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> ($past(bit_cnt) == CW'(BLK_BITS)));
  p_err_unmatched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> ($past(cls) == CL_NONE));
  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({emit_bit, gap_ev, err_ev, arm_ev}));
  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_valid && in_win) |=> (!ev_err && !blk_valid));
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> (!blk_valid && !ev_err));
  p_abort_with_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_abort) |-> ev_err);

endmodule

// File: tb/pulse_iv_demod_tb_top.sv
module pulse_iv_demod_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pk_valid = 1'b0;
  logic [15:0]  pk_time = '0;
  logic         blk_valid, ev_err, dec_abort, dec_done;
  logic [127:0] blk_data;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [15:0] tnow = '0;

  always #4 clk = ~clk;

  pulse_iv_demod dut_i (
    .clk(clk), .rst_n(rst_n), .pk_valid(pk_valid), .pk_time(pk_time),
    .blk_valid(blk_valid), .blk_data(blk_data), .ev_err(ev_err),
    .dec_abort(dec_abort), .dec_done(dec_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nfail++; nchk++;
      $display("FAIL all: watchdog expired act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pk_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic peak(input int len);
    tnow = tnow + 16'(len);
    @(negedge clk);
    pk_valid = 1'b1; pk_time = tnow;
    @(negedge clk);
    pk_valid = 1'b0;
  endtask

  task automatic peak_chk(input int len, input string req, input bit e_err, input bit e_blk);
    peak(len);
    check(req, 128'(ev_err), 128'(e_err));
    check(req, 128'(blk_valid), 128'(e_blk));
  endtask

  // expected class from the stated windows
  function automatic bit unmatched(input int d);
    bit q, h, f;
    q = (d > 16 - 8) && (d < 16 + 8);
    h = (d > 32 - 8) && (d < 32 + 8);
    f = (d > 64 - 8) && (d < 64 + 8);
    return !(q || h || f);
  endfunction

  // bits as full / half-half peaks with jitter; hfh puts 1,0 as H F H
  task automatic send_bits(input logic [131:0] pat, input int n, input bit hfh, input string req);
    bit skip_nx = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (skip_nx) skip_nx = 1'b0;
      else if (hfh && (k + 1 < n) && pat[k] && !pat[k+1]) begin
        peak_chk(32 + (k % 15) - 7, req, 1'b0, 1'b0);
        peak_chk(64 + ((k * 5) % 15) - 7, req, 1'b0, 1'b0);
        peak_chk(32 - (k % 15) + 7, req, 1'b0, 1'b0);
        skip_nx = 1'b1;
      end else if (pat[k]) begin
        peak_chk(64 + ((k * 5) % 15) - 7, req, 1'b0, 1'b0);
      end else begin
        peak_chk(32 + ((k * 3) % 15) - 7, req, 1'b0, 1'b0);
        peak_chk(32 + ((k * 7) % 15) - 7, req, 1'b0, 1'b0);
      end
    end
  endtask

  task automatic send_gap(input bit short_gap, input bit e_blk, input logic [127:0] e_data,
                          input bit e_done, input string req);
    peak_chk(16, req, 1'b0, 1'b0);
    peak(short_gap ? 32 : 16);
    check(req, 128'(blk_valid), 128'(e_blk));
    check(req, 128'(ev_err), 128'(0));
    if (e_blk) check({req, " R8 data"}, blk_data, e_data);
    check({req, " R9 done"}, 128'(dec_done), 128'(e_done));
    tnow = tnow + 16'(short_gap ? 335 : 351);
  endtask

  task automatic arm();
    tnow = 16'd900;
    peak_chk(100, "R2 first peak", 1'b0, 1'b0);
  endtask

  logic [131:0] p_one, p_zero, p_mix, p_alt;

  initial begin
    for (int k = 0; k < 132; k++) begin
      p_one[k]  = 1'b1;
      p_zero[k] = 1'b0;
      p_mix[k]  = (((k * 7 + 3) % 11) < 5);
      p_alt[k]  = (k % 2 == 0);
    end

    // R11 reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 blk_valid", 128'(blk_valid), 128'(0));
    check("R11 ev_err", 128'(ev_err), 128'(0));
    check("R11 abort", 128'(dec_abort), 128'(0));
    check("R11 done", 128'(dec_done), 128'(0));
    do_reset();
    check("R11 after", 128'({blk_valid, ev_err, dec_abort, dec_done}), 128'(0));

    // R1 interval sweep
    for (int d = 1; d <= 100; d++) begin
      do_reset();
      arm();
      peak_chk(d, "R1 class sweep", unmatched(d), 1'b0);
    end

    // Four blocks: R3 R4 R5 R8 R9
    do_reset();
    arm();
    send_bits(p_one, 128, 1'b0, "R3 ones");
    send_gap(1'b0, 1'b1, p_one[127:0], 1'b0, "R4 qq gap ones");
    send_bits(p_zero, 128, 1'b0, "R3 zeros");
    send_gap(1'b1, 1'b1, p_zero[127:0], 1'b0, "R5 qh gap zeros");
    send_bits(p_mix, 128, 1'b1, "R3 hfh mix");
    send_gap(1'b0, 1'b1, p_mix[127:0], 1'b0, "R3 mix block");
    send_bits(p_alt, 128, 1'b0, "R8 alt");
    send_gap(1'b1, 1'b1, p_alt[127:0], 1'b1, "R9 fourth block");
    send_bits(p_one, 128, 1'b0, "R9 after done");
    peak_chk(48, "R9 err after done", 1'b0, 1'b0);
    send_gap(1'b0, 1'b0, '0, 1'b1, "R9 gap after done");

    // R6 R7: bit count, skip window, pending half clear
    do_reset();
    arm();
    send_bits(p_mix, 127, 1'b0, "R7 short block");
    send_gap(1'b0, 1'b0, '0, 1'b0, "R7 127 bits");
    tnow = tnow - 16'd100;
    peak_chk(0, "R6 inside skip", 1'b0, 1'b0);
    tnow = tnow + 16'd100;
    peak_chk(0, "R6 at reference", 1'b0, 1'b0);
    send_bits(p_one, 129, 1'b0, "R7 long block");
    send_gap(1'b1, 1'b0, '0, 1'b0, "R7 129 bits");
    send_bits(p_alt, 127, 1'b0, "R7 pend");
    peak_chk(32, "R7 lone half", 1'b0, 1'b0);
    send_gap(1'b0, 1'b0, '0, 1'b0, "R7 127 plus half");
    send_bits(p_zero, 128, 1'b0, "R7 zeros after");
    send_gap(1'b0, 1'b1, p_zero[127:0], 1'b0, "R7 half flag cleared");

    // R10 error limit
    do_reset();
    arm();
    for (int e = 0; e < 10; e++) begin
      peak_chk(48, "R10 error", 1'b1, 1'b0);
      check("R10 no abort yet", 128'(dec_abort), 128'(0));
    end
    peak_chk(100, "R10 eleventh", 1'b1, 1'b0);
    check("R10 abort set", 128'(dec_abort), 128'(1));
    peak_chk(48, "R10 err after abort", 1'b0, 1'b0);
    send_bits(p_one, 128, 1'b0, "R10 bits after abort");
    send_gap(1'b0, 1'b0, '0, 1'b0, "R10 gap after abort");
    check("R10 abort held", 128'(dec_abort), 128'(1));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule